// File: doc/BRIEF.md
# Prescaled 16-bit Interval Timer

This block is a single 16-bit timer with a small 32-bit register port made of an address, a write strobe, write data and combinational read data. Software sets a counting direction, a power-of-two clock divider, an optional one-shot behaviour and a reload value. It then starts and stops the count through a command register. The counter advances once per divided tick.

Counting down past zero reloads the count from the top register and raises an underflow flag. Counting up past the top value wraps the count to zero and raises an overflow flag. In one-shot mode an underflow also halts the timer. Flags can be set or cleared through two alias registers, and a level interrupt reflects every enabled flag.

The run control is a two-state machine. `ST_IDLE` is the stopped state. The transition `GO` (a start command without a stop command) leads to `ST_RUN`. From `ST_RUN`, the transition `HALT` (a stop command) or the transition `EXPIRE` (an underflow in one-shot mode) leads back to `ST_IDLE`. All other cases hold the current state.

Top module: `ptimer_top`

## Requirements
- R1: After reset, every register reads as zero, the timer is stopped and `irq` is low.
- R2: Register offsets are as follows. Control is at 0x00, command at 0x04, enable at 0x0C, flags at 0x10, flag-set at 0x14, flag-clear at 0x18, top at 0x1C and count at 0x24.
  - Control reads back the divider field in bits 27:24, the one-shot bit in bit 4 and the mode in bits 1:0. Every other control bit reads zero.
  - Top and count keep only their low 16 bits.
  - Command bit 0 reads 1 while the timer runs.
  - Unmapped offsets, flag-set and flag-clear read zero.
- R3: Writing command bit 0 starts the timer and writing bit 1 stops it. When both bits are set, stop wins. A stopped count never changes unless software writes it.
- R4: With divider field n, the count moves once every 2^n clocks. The first move lands 2^n clocks after the start write. A field value above 10 behaves as 10.
- R5: In mode 1 the count decrements. On the tick after it reaches 0, it reloads from top and sets flag bit 1 (underflow).
- R6: In any mode other than 1 the count increments. On the tick after it equals top, it becomes 0 and sets flag bit 0 (overflow).
- R7: When control bit 4 (one-shot) is set, an underflow also stops the timer. The count is left at the top value and command bit 0 then reads 0.
- R8: Software may write the count while the timer is stopped. After a start, counting resumes from the written value.
- R9: A write to flag-set ORs the data into the flags. A write to flag-clear clears every flag bit written as 1. A hardware event in the same cycle as a clear leaves its flag set.
- R10: `irq` is high exactly when some flag bit and its enable bit are both 1. It drops in the clock after the last enabled flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A wrong run state shows up on command bit 0 at once. It also shows up in the count within one divided tick, as a count that creeps while it should be stopped or one that sits still while it should run. A divider or reload fault makes the count read off by at least one step after 2^n clocks. A wrong wrap point shows up one tick after the count reaches zero or top, either in the count or in the flag register. A flag or enable fault reaches `irq` one clock after the write or event that caused it.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    // Register byte offsets (software visible, fixed by the map)
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_IEN  = 8'h0C;
    localparam logic [7:0] OFS_FLAG = 8'h10;
    localparam logic [7:0] OFS_FSET = 8'h14;
    localparam logic [7:0] OFS_FCLR = 8'h18;
    localparam logic [7:0] OFS_TOP  = 8'h1C;
    localparam logic [7:0] OFS_CNT  = 8'h24;

    // Field positions
    localparam int CTRL_DIV_LSB = 24;
    localparam int CTRL_OS_BIT  = 4;
    localparam int FLAG_OF_BIT  = 0;
    localparam int FLAG_UF_BIT  = 1;
    localparam int NUM_FLAGS    = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [3:0] div_sel;
        logic       one_shot;
        logic [1:0] mode;
    } ctrl_t;

endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
    parameter int DIV_MAX = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [3:0] div_sel,
    output logic       tick
);
    localparam int PW = (DIV_MAX < 1) ? 1 : DIV_MAX;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] mask;
    int            eff;

    always_comb begin
        eff = (int'(div_sel) > DIV_MAX) ? DIV_MAX : int'(div_sel);
        for (int i = 0; i < PW; i++) begin
            mask[i] = (i < eff);
        end
    end

    assign tick = run && ((pcnt & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/ptimer_core.sv
module ptimer_core
    import ptimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             tick,
    input  logic             count_down,
    input  logic             one_shot,
    input  logic [CNT_W-1:0] top_val,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             uf_evt,
    output logic             of_evt
);
    run_state_e state, state_nxt;
    logic       step;

    assign step   = running && tick && !cnt_we;
    assign uf_evt = step && count_down && (cnt == '0);
    assign of_evt = step && !count_down && (cnt == top_val);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: GO, HALT, EXPIRE
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_cmd && !stop_cmd) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (stop_cmd) begin
                    state_nxt = ST_IDLE;
                end else if (one_shot && uf_evt) begin
                    state_nxt = ST_IDLE;
                end
            end
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        unique case (state)
            ST_IDLE: running = 1'b0;
            ST_RUN:  running = 1'b1;
        endcase
    end

    // Count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_we) begin
            cnt <= cnt_wdata;
        end else if (step) begin
            if (count_down) begin
                cnt <= (cnt == '0) ? top_val : cnt - 1'b1;
            end else begin
                cnt <= (cnt == top_val) ? '0 : cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
    import ptimer_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             running,
    input  logic             uf_evt,
    input  logic             of_evt,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] top_val,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] ien,
    output logic             start_cmd,
    output logic             stop_cmd,
    output logic             cnt_we,
    output logic [CNT_W-1:0] cnt_wdata,
    output logic             irq
);
    logic [7:0]           ofs;
    logic [NUM_FLAGS-1:0] hw_set, sw_set, sw_clr;

    assign ofs = 8'(addr);

    assign start_cmd = wr_en && (ofs == OFS_CMD) && wdata[0];
    assign stop_cmd  = wr_en && (ofs == OFS_CMD) && wdata[1];
    assign cnt_we    = wr_en && (ofs == OFS_CNT);
    assign cnt_wdata = wdata[CNT_W-1:0];

    assign sw_set = (wr_en && ofs == OFS_FSET) ? wdata[NUM_FLAGS-1:0] : '0;
    assign sw_clr = (wr_en && ofs == OFS_FCLR) ? wdata[NUM_FLAGS-1:0] : '0;

    always_comb begin
        hw_set              = '0;
        hw_set[FLAG_UF_BIT] = uf_evt;
        hw_set[FLAG_OF_BIT] = of_evt;
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            ien     <= '0;
            top_val <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_CTRL: begin
                    ctrl.div_sel  <= wdata[CTRL_DIV_LSB +: 4];
                    ctrl.one_shot <= wdata[CTRL_OS_BIT];
                    ctrl.mode     <= wdata[1:0];
                end
                OFS_IEN: ien     <= wdata[NUM_FLAGS-1:0];
                OFS_TOP: top_val <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Flags: hardware events win over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= ((flags | sw_set) & ~sw_clr) | hw_set;
        end
    end

    assign irq = |(flags & ien);

    // Read mux
    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_CTRL: begin
                rdata[CTRL_DIV_LSB +: 4] = ctrl.div_sel;
                rdata[CTRL_OS_BIT]       = ctrl.one_shot;
                rdata[1:0]               = ctrl.mode;
            end
            OFS_CMD:  rdata[0]                 = running;
            OFS_IEN:  rdata[NUM_FLAGS-1:0]     = ien;
            OFS_FLAG: rdata[NUM_FLAGS-1:0]     = flags;
            OFS_TOP:  rdata[CNT_W-1:0]         = top_val;
            OFS_CNT:  rdata[CNT_W-1:0]         = cnt;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int CNT_W   = 16,
    parameter int DIV_MAX = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    ctrl_t                ctrl;
    logic [CNT_W-1:0]     top_val, cnt_val, cnt_wdata;
    logic [NUM_FLAGS-1:0] flags, ien;
    logic                 start_cmd, stop_cmd, cnt_we;
    logic                 running, uf_evt, of_evt, tick;
    logic                 count_down;

    assign count_down = (ctrl.mode == 2'd1);

    ptimer_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .cnt(cnt_val), .running(running),
        .uf_evt(uf_evt), .of_evt(of_evt), .ctrl(ctrl), .top_val(top_val),
        .flags(flags), .ien(ien), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .irq(irq)
    );

    ptimer_prescaler #(.DIV_MAX(DIV_MAX)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(start_cmd), .run(running),
        .div_sel(ctrl.div_sel), .tick(tick)
    );

    ptimer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .tick(tick), .count_down(count_down), .one_shot(ctrl.one_shot),
        .top_val(top_val), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cnt(cnt_val), .running(running), .uf_evt(uf_evt), .of_evt(of_evt)
    );

endmodule

// File: rtl/ptimer_sva.sv
module ptimer_sva
    import ptimer_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [AW-1:0]        addr,
    input logic                 wr_en,
    input logic [DW-1:0]        wdata,
    input logic                 irq,
    input logic                 running,
    input logic [CNT_W-1:0]     cnt_val,
    input logic                 uf_evt,
    input logic                 of_evt,
    input logic                 one_shot,
    input logic                 cnt_we,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_FLAGS-1:0] ien
);
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_we) |=> $stable(cnt_val)); // R3

    AST_UF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> flags[FLAG_UF_BIT]); // R5

    AST_OF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        of_evt |=> flags[FLAG_OF_BIT]); // R6

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && one_shot) |=> !running); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 8'(addr) == OFS_FCLR && wdata[FLAG_UF_BIT] && !uf_evt)
        |=> !flags[FLAG_UF_BIT]); // R9

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 8'(addr) == OFS_FCLR && uf_evt) |=> flags[FLAG_UF_BIT]); // R9

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq); // R10

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (flags != '0)); // R10

endmodule

bind ptimer_top ptimer_sva #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .irq(irq), .running(running), .cnt_val(cnt_val), .uf_evt(uf_evt),
    .of_evt(of_evt), .one_shot(ctrl.one_shot), .cnt_we(cnt_we),
    .flags(flags), .ien(ien)
);

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    ptimer_top u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_count(bit down, bit os, int c, int top, int ticks);
        if (down) begin
            if (ticks <= c) return c - ticks;
            if (os) return top;
            return top - ((ticks - c - 1) % (top + 1));
        end
        return (c + ticks) % (top + 1);
    endfunction

    function automatic logic [31:0] exp_flags(bit down, int c, int top, int ticks);
        if (down) return (ticks > c) ? 32'h2 : 32'h0;
        return (c + ticks > top) ? 32'h1 : 32'h0;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        process::self().srandom(32'd1234);
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h04, v); check("R1 cmd", v, 0);
        rd(8'h0C, v); check("R1 ien", v, 0);
        rd(8'h10, v); check("R1 flags", v, 0);
        rd(8'h1C, v); check("R1 top", v, 0);
        rd(8'h24, v); check("R1 cnt", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 decode and field readback
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R2 ctrl mask", v, 32'h0F00_0013);
        wr(8'h00, 32'h0A03_0011);
        rd(8'h00, v); check("R2 ctrl fields", v, 32'h0A00_0011);
        wr(8'h1C, 32'h0001_2345);
        rd(8'h1C, v); check("R2 top width", v, 32'h2345);
        rd(8'h08, v); check("R2 unmapped", v, 0);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, v); check("R2 ien", v, 32'h3);
        wr(8'h0C, 0);

        // R3 stop wins, stopped count holds
        wr(8'h00, 32'h0000_0001);
        wr(8'h24, 32'd7);
        wr(8'h04, 32'h3);
        rd(8'h04, v); check("R3 stop wins", v, 0);
        idle(20);
        rd(8'h24, v); check("R3 stopped holds", v, 7);

        // R8 written count resumes after start; R4 prescaler n=2
        wr(8'h00, 32'h0200_0001);
        wr(8'h24, 32'd20);
        wr(8'h04, 32'h1);
        rd(8'h04, v); check("R3 running", v, 1);
        idle(3);
        rd(8'h24, v); check("R4 before first step", v, 20);
        idle(1);
        rd(8'h24, v); check("R8 resumes from written", v, 19);
        wr(8'h04, 32'h2);

        // R4 divider field above 10 acts as 10
        wr(8'h00, 32'h0B00_0001);
        wr(8'h24, 32'd5);
        wr(8'h04, 32'h1);
        idle(1023);
        rd(8'h24, v); check("R4 clamp before", v, 5);
        idle(1);
        rd(8'h24, v); check("R4 clamp step", v, 4);
        wr(8'h04, 32'h2);

        // R7 one-shot down
        wr(8'h10 + 8'h08, 32'h3);
        wr(8'h00, 32'h0000_0011);
        wr(8'h1C, 32'd9);
        wr(8'h24, 32'd2);
        wr(8'h04, 32'h1);
        idle(3);
        rd(8'h24, v); check("R7 reload to top", v, 9);
        rd(8'h04, v); check("R7 halted", v, 0);
        rd(8'h10, v); check("R5 underflow flag", v, 32'h2);
        idle(5);
        rd(8'h24, v); check("R7 stays", v, 9);

        // R9 set/clear aliases, R10 irq
        wr(8'h18, 32'h3);
        wr(8'h14, 32'h1);
        rd(8'h10, v); check("R9 set", v, 1);
        wr(8'h14, 32'h2);
        rd(8'h10, v); check("R9 set or", v, 3);
        rd(8'h14, v); check("R2 set alias reads zero", v, 0);
        wr(8'h18, 32'h1);
        rd(8'h10, v); check("R9 clear", v, 2);
        wr(8'h0C, 32'h2);
        check("R10 irq on", {31'b0, irq}, 1);
        wr(8'h0C, 32'h1);
        check("R10 irq masked", {31'b0, irq}, 0);
        wr(8'h0C, 32'h2);
        wr(8'h18, 32'h2);
        check("R10 irq drops", {31'b0, irq}, 0);

        // R5 R6 R7 R8 random runs
        for (int it = 0; it < 40; it++) begin
            int n, top, c, w, ticks, e;
            bit down, os;
            logic [31:0] en;
            n     = int'($urandom % 4);
            down  = $urandom % 2;
            os    = $urandom % 2;
            top   = 5 + int'($urandom % 20);
            c     = int'($urandom % (top + 1));
            w     = int'($urandom % (3 * (top + 1) * (1 << n)));
            en    = $urandom % 4;
            ticks = w >> n;
            wr(8'h04, 32'h2);
            wr(8'h18, 32'h3);
            wr(8'h00, (32'(n) << 24) | (32'(os) << 4) | 32'(down));
            wr(8'h1C, 32'(top));
            wr(8'h0C, en);
            wr(8'h24, 32'(c));
            wr(8'h04, 32'h1);
            idle(w);
            e = exp_count(down, os, c, top, ticks);
            rd(8'h24, v);
            check(down ? (os ? "R7 count" : "R5 count") : "R6 count", v, 32'(e));
            rd(8'h10, v);
            check(down ? "R5 flag" : "R6 flag", v, exp_flags(down, c, top, ticks));
            rd(8'h04, v);
            check("R7 run state", v, (down && os && ticks > c) ? 0 : 1);
            check("R10 irq", {31'b0, irq}, {31'b0, |(exp_flags(down, c, top, ticks) & en)});
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule